// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block is a reusable rendezvous point for a fixed pool of participants. Every participant owns an arrive pulse and two outputs. `wait_o` is held high while the participant is parked at the barrier. `release_o` pulses high when the whole group has gathered. A shared arrival counter and a single global release flag are kept in the block. Each participant slot keeps a private sense bit that inverts every time the participant enters the barrier. A slot is parked exactly while its sense matches the global flag.

When the last member of the group arrives, the counter returns to zero. The flag then takes the sense the arrivals carried into the barrier, which is the inverse of the sense they now hold. Because completion inverts the flag rather than first clearing it and later setting it, a participant that leaves and comes straight back cannot disturb a slower one that has not yet seen its release. Any number of arrivals in one cycle are merged and counted together. The group size is the `N_PART` parameter, or the `total_i` input when `RUNTIME_TOTAL` is set.

Top module: `barrier_top`

## Requirements
- R1: After reset every slot sense is 1 and the global flag is 0. All `wait_o` and `release_o` bits are 0, and the arrival count is 0.
- R2: An accepted arrival (`arrive_i[i]` high while `wait_o[i]` is low, for an active slot) raises `wait_o[i]` on the next cycle and adds one to the count, unless it completes the round.
- R3: When the count plus this cycle's accepted arrivals equals the group size, the next cycle has the count at 0 and `wait_o` low for every slot. Every slot that was waiting or arriving pulses `release_o` for that single cycle.
- R4: Arrivals from several slots in one cycle are all counted. Completion is judged after the whole batch is added, so a full group arriving together is released one cycle later.
- R5: An arrive pulse from a slot whose `wait_o` is high is ignored. It neither adds to the count nor changes that slot's state.
- R6: A released slot may arrive again in its `release_o` cycle or later. It then waits for the next full round and does not release or stall the others.
- R7: With `RUNTIME_TOTAL` set, the group size is `total_i`, in the range 1 to `N_PART`. Slots with index `i < total_i` are active. Otherwise the group size is `N_PART` and every slot is active.
- R8: An inactive slot ignores `arrive_i`. It never raises `wait_o` or `release_o`, and it follows the flag so that it is idle when it becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arrive_i | input | N_PART | Per-slot arrival pulse |
| total_i | input | $clog2(N_PART+1) | Runtime group size, used when RUNTIME_TOTAL is 1 |
| wait_o | output | N_PART | Slot is parked at the barrier |
| release_o | output | N_PART | One-cycle pulse when the slot's round completes |

## Verification
The properties assume that `total_i` lies between 1 and `N_PART`. They also assume it changes only while the count is zero and no slot is waiting, so the count always stays below the group size. The stimulus keeps to this: it changes `total_i` only on an idle cycle after a completed round, and it raises arrive bits on inactive slots only to show that they are dropped. Repeated arrive pulses from parked slots, and re-entry during the release pulse, are driven on purpose. These inputs are legal, and the properties expect them to be absorbed.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    localparam logic SENSE_AT_RESET = 1'b1;
    localparam logic FLAG_AT_RESET  = 1'b0;

    // Sense a slot holds after this cycle: inverted on an accepted entry.
    function automatic logic sense_step(input logic cur, input logic entering);
        return entering ? ~cur : cur;
    endfunction

endpackage

// File: rtl/barrier_arrival_merge.sv
module barrier_arrival_merge #(
    parameter int N_PART = 4,
    localparam int CW = $clog2(N_PART + 1)
) (
    input  logic [N_PART-1:0] arrive_i,
    input  logic [N_PART-1:0] waiting_i,
    input  logic [N_PART-1:0] active_i,
    output logic [N_PART-1:0] accept_o,
    output logic [CW-1:0]     batch_o
);

    always_comb begin
        accept_o = arrive_i & ~waiting_i & active_i;
        batch_o  = '0;
        for (int k = 0; k < N_PART; k++) begin
            batch_o = batch_o + CW'(accept_o[k]);
        end
    end

endmodule

// File: rtl/barrier_sense_slot.sv
module barrier_sense_slot
    import barrier_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic accept_i,
    input  logic complete_i,
    input  logic flag_q_i,
    input  logic flag_d_i,
    output logic waiting_o,
    output logic release_o
);

    typedef struct packed {
        logic sense;
        logic rel;
    } slot_t;

    slot_t slot_d, slot_q;

    // A slot is parked while its private sense matches the global flag.
    assign waiting_o = active_i && (slot_q.sense == flag_q_i);
    assign release_o = slot_q.rel;

    always_comb begin
        slot_d = slot_q;
        if (active_i) begin
            slot_d.sense = sense_step(slot_q.sense, accept_i);
        end else begin
            // Inactive slots track the flag so that they stay idle.
            slot_d.sense = ~flag_d_i;
        end
        slot_d.rel = complete_i && active_i && (waiting_o || accept_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q.sense <= SENSE_AT_RESET;
            slot_q.rel   <= 1'b0;
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/barrier_top.sv
module barrier_top
    import barrier_pkg::*;
#(
    parameter int N_PART        = 4,
    parameter bit RUNTIME_TOTAL = 1'b1,
    localparam int CW = $clog2(N_PART + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_PART-1:0] arrive_i,
    input  logic [CW-1:0]     total_i,
    output logic [N_PART-1:0] wait_o,
    output logic [N_PART-1:0] release_o
);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          flag;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic [CW-1:0]     total_eff;
    logic [N_PART-1:0] active;
    logic [N_PART-1:0] accept;
    logic [CW-1:0]     batch;
    logic [CW:0]       sum;
    logic              complete;

    generate
        if (RUNTIME_TOTAL) begin : g_rt_total
            assign total_eff = total_i;
        end else begin : g_fixed_total
            logic [CW-1:0] unused_total;
            assign unused_total = total_i;
            assign total_eff    = CW'(N_PART);
        end
    endgenerate

    for (genvar gi = 0; gi < N_PART; gi++) begin : g_active
        assign active[gi] = total_eff > CW'(gi);
    end

    barrier_arrival_merge #(.N_PART(N_PART)) u_merge (
        .arrive_i (arrive_i),
        .waiting_i(wait_o),
        .active_i (active),
        .accept_o (accept),
        .batch_o  (batch)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        sum      = {1'b0, ctrl_q.count} + {1'b0, batch};
        complete = (batch != '0) && (sum == {1'b0, total_eff});
        if (complete) begin
            ctrl_d.count = '0;
            // Flag takes the sense the arrivals carried in (before inverting).
            ctrl_d.flag  = ~ctrl_q.flag;
        end else begin
            ctrl_d.count = sum[CW-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.count <= '0;
            ctrl_q.flag  <= FLAG_AT_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar gs = 0; gs < N_PART; gs++) begin : g_slot
        barrier_sense_slot u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .active_i  (active[gs]),
            .accept_i  (accept[gs]),
            .complete_i(complete),
            .flag_q_i  (ctrl_q.flag),
            .flag_d_i  (ctrl_d.flag),
            .waiting_o (wait_o[gs]),
            .release_o (release_o[gs])
        );
    end

endmodule

// File: rtl/barrier_checker.sv
module barrier_checker #(
    parameter int N_PART = 4,
    localparam int CW = $clog2(N_PART + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [N_PART-1:0] arrive_i,
    input logic [N_PART-1:0] wait_o,
    input logic [N_PART-1:0] release_o,
    input logic [CW-1:0]     count_q,
    input logic [CW-1:0]     total_eff
);

    // R3: the count never reaches the group size; it folds to zero first
    assert_count_below_total_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q < total_eff);

    // R3: in a release cycle nobody is parked
    assert_release_clears_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|release_o) |-> (wait_o == '0));

    // R3: a completing round leaves the count at zero
    assert_release_zero_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|release_o) |-> (count_q == '0));

    for (genvar gi = 0; gi < N_PART; gi++) begin : g_per_slot
        // R2: parking only follows an arrive pulse
        assert_wait_needs_arrive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(wait_o[gi]) |-> $past(arrive_i[gi]));

        // R5: a parked slot pulsing arrive stays parked unless released
        assert_parked_arrive_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wait_o[gi] && arrive_i[gi]) |=> (wait_o[gi] || release_o[gi]));

        // R3: release only for a slot that was waiting or arriving
        assert_release_from_round_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            release_o[gi] |-> ($past(wait_o[gi]) || $past(arrive_i[gi])));
    end

endmodule

bind barrier_top barrier_checker #(.N_PART(N_PART)) u_barrier_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arrive_i (arrive_i),
    .wait_o   (wait_o),
    .release_o(release_o),
    .count_q  (ctrl_q.count),
    .total_eff(total_eff)
);

// File: tb/test_barrier_top.sv
`timescale 1ns/1ps
module test_barrier_top;

    localparam int N  = 4;
    localparam int CW = $clog2(N + 1);

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [N-1:0]  arrive_i = '0;
    logic [CW-1:0] total_i = CW'(N);
    logic [N-1:0]  wait_o;
    logic [N-1:0]  release_o;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [N-1:0] w;
        logic [N-1:0] r;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state built from the requirements
    logic [N-1:0]  m_sense = '1;
    logic          m_flag  = 1'b0;
    int            m_cnt   = 0;

    always #2.5 clk_i = ~clk_i;

    barrier_top #(.N_PART(N), .RUNTIME_TOTAL(1'b1)) i_barrier_top (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .arrive_i (arrive_i),
        .total_i  (total_i),
        .wait_o   (wait_o),
        .release_o(release_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] expv);
        tests++;
        if (act !== expv) begin
            failed++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
        end
    endtask

    // Driver: applies one cycle of arrivals and pushes the expected outcome
    task automatic step(input logic [N-1:0] arr, input string tag);
        logic [N-1:0] act, waitv, acc, nsense, ew, er;
        int n;
        logic comp, nflag;
        @(negedge clk_i);
        arrive_i = arr;
        for (int i = 0; i < N; i++) act[i] = (i < int'(total_i));
        for (int i = 0; i < N; i++) waitv[i] = act[i] && (m_sense[i] == m_flag);
        acc = arr & ~waitv & act;
        n = 0;
        for (int i = 0; i < N; i++) n += int'(acc[i]);
        comp  = (n != 0) && (m_cnt + n == int'(total_i));
        nflag = comp ? ~m_flag : m_flag;
        for (int i = 0; i < N; i++)
            nsense[i] = act[i] ? (acc[i] ? ~m_sense[i] : m_sense[i]) : ~nflag;
        for (int i = 0; i < N; i++) begin
            ew[i] = act[i] && (nsense[i] == nflag);
            er[i] = comp && act[i] && (waitv[i] || acc[i]);
        end
        m_cnt   = comp ? 0 : m_cnt + n;
        m_flag  = nflag;
        m_sense = nsense;
        exp_q.push_back('{w: ew, r: er, tag: tag});
    endtask

    task automatic idle(input int cycles, input string tag);
        for (int c = 0; c < cycles; c++) step('0, tag);
    endtask

    // Monitor: pops one expectation per clock, sampled after the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk_i);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(e.tag, "wait_o", wait_o, e.w);
                check(e.tag, "release_o", release_o, e.r);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", "wait_o after reset", wait_o, '0);
        check("R1", "release_o after reset", release_o, '0);

        // R2 R3: one at a time, release on the fourth
        step(4'b0001, "R2");
        step(4'b0010, "R2");
        step(4'b0100, "R2");
        step(4'b1000, "R3");
        idle(2, "R3");

        // R4: whole group in one cycle, then two pairs
        step(4'b1111, "R4");
        idle(1, "R4");
        step(4'b0011, "R4");
        step(4'b1100, "R4");
        idle(1, "R4");

        // R5: repeated pulses from a parked slot are dropped
        step(4'b0001, "R5");
        step(4'b0001, "R5");
        step(4'b0001, "R5");
        step(4'b0010, "R5");
        step(4'b0100, "R5");
        step(4'b0101, "R5");
        step(4'b1000, "R5");

        // R6: fast re-entry during the release pulse, slow others after
        step(4'b0001, "R6");
        step(4'b0010, "R6");
        step(4'b1100, "R6");
        step(4'b0001, "R6");
        step(4'b0010, "R6");
        step(4'b0100, "R6");
        step(4'b0001, "R6");
        step(4'b1000, "R6");
        idle(2, "R6");

        // R7 R8: group of three, slot 3 inactive
        @(negedge clk_i);
        total_i = CW'(3);
        step(4'b1000, "R8");
        step(4'b0001, "R7");
        step(4'b1010, "R8");
        step(4'b0100, "R7");
        idle(1, "R7");
        step(4'b1111, "R8");
        idle(1, "R8");

        // R7: group of one releases every entry, even back to back
        @(negedge clk_i);
        total_i = CW'(1);
        step(4'b0001, "R7");
        step(4'b0001, "R7");
        step(4'b0011, "R8");
        idle(1, "R7");

        // R8: growing the group again starts the new slots idle
        @(negedge clk_i);
        total_i = CW'(4);
        step(4'b1000, "R8");
        step(4'b0111, "R8");
        idle(2, "R8");

        while (exp_q.size() > 0) @(negedge clk_i);
        @(negedge clk_i);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule